// File: doc/BRIEF.md
# Blanking-Time Scanline Prefetch Buffer

This block keeps the visible part of a scanline off the video memory bus. Each time horizontal blanking begins, it decides whether the coming display line needs new data. If it does, it reads one burst of 80 consecutive bytes from a synchronous video memory and stores them in an on-chip line buffer. The pixel pipeline then reads that buffer one column at a time while the beam crosses the active area. The memory is touched only during blanking.

There are two modes. In bitmap mode (320x200, 2 bits per pixel, 4 pixels per byte), every display line gets its own 80-byte burst. In text mode (80 columns by 25 rows, 8x8 cells), the character codes for the next row are fetched on the blanking after the first line of a row. The attribute bytes for that row (4-bit foreground, 4-bit background) are fetched on the blanking after the second line.

Both buffers hold two banks, selected by the parity of the line (bitmap) or of the row (text). A fetch for the next line or row therefore never disturbs the one on screen. Font lookup and colour generation live downstream.

Top module: `scanPrefetch`

## Requirements
- R1: After reset, `busReq` and `memRd` are low and `pixByte` and `attrByte` read 0.
- R2: In bitmap mode, on every rise of `hBlank` the block issues exactly 80 reads, one per clock, starting the cycle after the rise. The addresses run consecutively from `pageBase + (curLine+1)*80`, modulo 2^ADDR_W. The data goes to the pixel buffer bank `(curLine+1)` bit 0.
- R3: In text mode with `curLine[2:0] == 0`, the burst reads the character row `curLine/8 + 1` from `pageBase + row*80` into pixel buffer bank `row` bit 0.
- R4: In text mode with `curLine[2:0] == 1`, the burst reads the attribute row `curLine/8 + 1` from `pageBase + ATTR_BASE + row*80` into attribute buffer bank `row` bit 0.
- R5: In text mode with `curLine[2:0]` of 2 to 7, a blanking interval issues no read, and `busReq` stays low for the whole interval.
- R6: `busReq` is high only while `hBlank` is high. It stays high from the first read through the cycle in which the 80th byte returns, and is low on the following cycle.
- R7: If `hBlank` falls before the burst is complete, `memRd` and `busReq` go low in that same cycle, and no further reads follow.
- R8: The buffer bank on display is bit 0 of `curLine` in bitmap mode and bit 3 of `curLine` in text mode. A burst into the other bank leaves the displayed bank's contents unchanged.
- R9: `pixByte` and `attrByte` give the byte at column `rdCol` of the displayed bank one clock after `rdCol` is sampled.
- R10: `memData` is captured one clock after the `memRd` cycle that requested it. Byte k of a burst lands at column k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| hBlank | input | 1 | High during horizontal blanking |
| textMode | input | 1 | 1 = text mode, 0 = bitmap mode |
| curLine | input | Y_W | Display line just drawn or being drawn |
| pageBase | input | ADDR_W | Start address of the displayed page |
| memRd | output | 1 | Read strobe to video memory |
| memAddr | output | ADDR_W | Read address to video memory |
| memData | input | DATA_W | Read data, valid one clock after `memRd` |
| busReq | output | 1 | Memory bus request, held for the burst |
| rdCol | input | COL_W | Column read by the pixel pipeline |
| pixByte | output | DATA_W | Bitmap byte or character code at `rdCol` |
| attrByte | output | DATA_W | Attribute byte at `rdCol` |

## Verification
The bench builds the block with LINE_BYTES 80, ADDR_W 14, Y_W 10 and ATTR_BASE 0x800. The 14-bit address space lets random page bases near its top wrap partway through a burst. The 10-bit line counter reaches every line of a 200-line frame. A short blanking interval exercises the aborted burst. Alternating bursts into both banks followed by read-back show that the displayed bank survives a fetch into the other one.

// File: rtl/scanPrefetchPkg.sv
package scanPrefetchPkg;
  // Strobes from the control FSM to the buffer datapath
  typedef struct packed {
    logic load;     // latch the start address, clear the write column
    logic issue;    // a memory read is issued this cycle
    logic capture;  // memData holds the byte of the previous issue
    logic attrSel;  // target is the attribute buffer
    logic bank;     // target bank for capture
  } fetchCmd_t;
endpackage

// File: rtl/scanPrefetchCtrl.sv
module scanPrefetchCtrl
  import scanPrefetchPkg::*;
#(
  parameter int LINE_BYTES = 80,
  parameter int Y_W        = 10,
  parameter int COL_W      = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hBlank,
  input  logic           textMode,
  input  logic [Y_W-1:0] curLine,
  output fetchCmd_t      cmd,
  output logic [Y_W-1:0] tgtIdx,
  output logic           busReq,
  output logic           dispBank
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_BYTES - 1);

  logic hBlankQ, active, wrPend, tgtAttrQ, tgtBankQ;
  logic [COL_W-1:0] issueCnt;
  logic wantChar, wantAttr, needFetch, startNow, issue;
  logic [Y_W-1:0] lineNext, rowNext;

  always_comb begin
    lineNext  = curLine + 1'b1;
    rowNext   = (curLine >> 3) + 1'b1;
    wantChar  = textMode && (curLine[2:0] == 3'd0);
    wantAttr  = textMode && (curLine[2:0] == 3'd1);
    needFetch = !textMode || wantChar || wantAttr;
    startNow  = hBlank && !hBlankQ && needFetch;
    tgtIdx    = textMode ? rowNext : lineNext;
    issue     = active && hBlank;
    cmd.load    = startNow;
    cmd.issue   = issue;
    cmd.capture = wrPend;
    cmd.attrSel = startNow ? wantAttr : tgtAttrQ;
    cmd.bank    = tgtBankQ;
    busReq      = hBlank && (active || wrPend);
    dispBank    = textMode ? curLine[3] : curLine[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hBlankQ  <= 1'b0;
      active   <= 1'b0;
      wrPend   <= 1'b0;
      tgtAttrQ <= 1'b0;
      tgtBankQ <= 1'b0;
      issueCnt <= '0;
    end else begin
      hBlankQ <= hBlank;
      wrPend  <= issue;
      if (startNow) begin
        active   <= 1'b1;
        issueCnt <= '0;
        tgtAttrQ <= wantAttr;
        tgtBankQ <= tgtIdx[0];
      end else if (issue) begin
        issueCnt <= issueCnt + 1'b1;
        if (issueCnt == LAST_COL) active <= 1'b0;
      end else if (!hBlank) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scanPrefetchData.sv
module scanPrefetchData
  import scanPrefetchPkg::*;
#(
  parameter int LINE_BYTES = 80,
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int Y_W        = 10,
  parameter int COL_W      = 7,
  parameter int ATTR_BASE  = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchCmd_t         cmd,
  input  logic [Y_W-1:0]    tgtIdx,
  input  logic [ADDR_W-1:0] pageBase,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              dispBank,
  input  logic [COL_W-1:0]  rdCol,
  output logic [DATA_W-1:0] pixByte,
  output logic [DATA_W-1:0] attrByte
);
  localparam int NUM_BANKS = 2;

  logic [ADDR_W-1:0] addrQ, startAddr, attrOfs;
  logic [COL_W-1:0]  wrCol;
  logic [DATA_W-1:0] pixRd  [NUM_BANKS];
  logic [DATA_W-1:0] attrRd [NUM_BANKS];

  always_comb begin
    attrOfs   = cmd.attrSel ? ADDR_W'(ATTR_BASE) : '0;
    startAddr = pageBase + attrOfs + ADDR_W'(tgtIdx) * ADDR_W'(LINE_BYTES);
  end

  assign memAddr = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      wrCol <= '0;
    end else begin
      if (cmd.load)         addrQ <= startAddr;
      else if (cmd.issue)   addrQ <= addrQ + 1'b1;
      if (cmd.load)         wrCol <= '0;
      else if (cmd.capture) wrCol <= wrCol + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] pixMem  [LINE_BYTES];
    logic [DATA_W-1:0] attrMem [LINE_BYTES];
    logic hit;
    assign hit = cmd.capture && (cmd.bank == b[0]);
    always_ff @(posedge clk) begin
      if (hit && !cmd.attrSel) pixMem[wrCol]  <= memData;
      if (hit &&  cmd.attrSel) attrMem[wrCol] <= memData;
    end
    assign pixRd[b]  = pixMem[rdCol];
    assign attrRd[b] = attrMem[rdCol];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixByte  <= '0;
      attrByte <= '0;
    end else begin
      pixByte  <= pixRd[dispBank];
      attrByte <= attrRd[dispBank];
    end
  end
endmodule

// File: rtl/scanPrefetch.sv
module scanPrefetch
  import scanPrefetchPkg::*;
#(
  parameter int LINE_BYTES = 80,
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int Y_W        = 10,
  parameter int ATTR_BASE  = 2000,
  localparam int COL_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hBlank,
  input  logic              textMode,
  input  logic [Y_W-1:0]    curLine,
  input  logic [ADDR_W-1:0] pageBase,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              busReq,
  input  logic [COL_W-1:0]  rdCol,
  output logic [DATA_W-1:0] pixByte,
  output logic [DATA_W-1:0] attrByte
);
  fetchCmd_t      cmd;
  logic [Y_W-1:0] tgtIdx;
  logic           dispBank;

  scanPrefetchCtrl #(.LINE_BYTES(LINE_BYTES), .Y_W(Y_W), .COL_W(COL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hBlank(hBlank), .textMode(textMode),
    .curLine(curLine), .cmd(cmd), .tgtIdx(tgtIdx), .busReq(busReq),
    .dispBank(dispBank)
  );

  scanPrefetchData #(
    .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .Y_W(Y_W), .COL_W(COL_W), .ATTR_BASE(ATTR_BASE)
  ) i_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tgtIdx(tgtIdx), .pageBase(pageBase),
    .memAddr(memAddr), .memData(memData), .dispBank(dispBank), .rdCol(rdCol),
    .pixByte(pixByte), .attrByte(attrByte)
  );

  assign memRd = cmd.issue;
endmodule

// File: rtl/scanPrefetchChk.sv
module scanPrefetchChk #(
  parameter int LINE_BYTES = 80,
  parameter int ADDR_W     = 14,
  parameter int Y_W        = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              hBlank,
  input logic              textMode,
  input logic [Y_W-1:0]    curLine,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busReq
);
  logic [15:0] burstCnt;
  logic        blankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstCnt <= '0;
      blankQ   <= 1'b0;
    end else begin
      blankQ <= hBlank;
      if (hBlank && !blankQ) burstCnt <= '0;
      else if (memRd)        burstCnt <= burstCnt + 1'b1;
    end
  end

  AST_REQ_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> hBlank);                                              // R6
  AST_READ_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busReq);                                               // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr == $past(memAddr) + 1'b1)); // R2
  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    burstCnt <= 16'(LINE_BYTES));                                    // R2
  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hBlank) && (!textMode || curLine[2:1] == 2'b00)) |=> busReq); // R3
  AST_TEXT_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hBlank) && textMode && curLine[2:1] != 2'b00) |=> !busReq);   // R5
endmodule

bind scanPrefetch scanPrefetchChk #(
  .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .Y_W(Y_W)
) i_scanPrefetchChk (
  .clk(clk), .rstN(rstN), .hBlank(hBlank), .textMode(textMode),
  .curLine(curLine), .memRd(memRd), .memAddr(memAddr), .busReq(busReq)
);

// File: tb/test_scanPrefetch.sv
module test_scanPrefetch;
  localparam int LB = 80;
  localparam int AW = 14;
  localparam int DW = 8;
  localparam int YW = 10;
  localparam int AB = 14'h0800;
  localparam int CW = $clog2(LB);

  logic clk = 1'b0, rstN = 1'b0, hBlank = 1'b0, textMode = 1'b0;
  logic [YW-1:0] curLine = '0;
  logic [AW-1:0] pageBase = '0;
  logic memRd, busReq;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData = '0, pixByte, attrByte;
  logic [CW-1:0] rdCol = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scanPrefetch #(.LINE_BYTES(LB), .ADDR_W(AW), .DATA_W(DW), .Y_W(YW), .ATTR_BASE(AB))
  i_scanPrefetch (
    .clk(clk), .rstN(rstN), .hBlank(hBlank), .textMode(textMode), .curLine(curLine),
    .pageBase(pageBase), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .busReq(busReq), .rdCol(rdCol), .pixByte(pixByte), .attrByte(attrByte)
  );

  function automatic logic [DW-1:0] memFn(logic [AW-1:0] a);
    return DW'(a * 7 + (a >> 8) * 3 + 1) ^ DW'(a >> 5);
  endfunction

  // synchronous memory model: data one clock after the read strobe (R10)
  always @(posedge clk) if (memRd) memData <= memFn(memAddr);

  function automatic logic [AW-1:0] startOf(int line, bit tm, logic [AW-1:0] base);
    int idx;
    idx = tm ? (line / 8 + 1) : (line + 1);
    return base + ((tm && (line % 8 == 1)) ? AW'(AB) : AW'(0)) + AW'(idx * LB);
  endfunction

  function automatic bit fetchesOn(int line, bit tm);
    return !tm || (line % 8 < 2);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one blanking interval of len cycles, checking reads and request cycle by cycle
  task automatic blankRun(int line, bit tm, logic [AW-1:0] base, int len, string req);
    logic [AW-1:0] st;
    bit fe;
    int bad, firstAct, firstExp;
    st = startOf(line, tm, base);
    fe = fetchesOn(line, tm);
    bad = 0; firstAct = 0; firstExp = 0;
    @(negedge clk);
    curLine = YW'(line); textMode = tm; pageBase = base; hBlank = 1'b0;
    repeat (3) @(negedge clk);
    hBlank = 1'b1;
    for (int k = 1; k <= len; k++) begin
      bit expRd, expReq;
      @(negedge clk);
      expRd  = fe && k <= LB;
      expReq = fe && k <= LB + 1;
      if (memRd !== expRd || busReq !== expReq ||
          (expRd && memAddr !== st + AW'(k - 1))) begin
        if (bad == 0) begin
          firstAct = {memRd, busReq, memAddr};
          firstExp = {expRd, expReq, st + AW'(k - 1)};
        end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
    hBlank = 1'b0;
    #1;
    check(memRd === 1'b0 && busReq === 1'b0, "R6 request low after blank", {memRd, busReq}, 0);
  endtask

  // read a bank back through the column port (one clock latency, R9)
  task automatic readBack(int line, bit tm, logic [AW-1:0] pixSt, logic [AW-1:0] attrSt,
                          bit withAttr, string req);
    int bad, act, exp;
    bad = 0; act = 0; exp = 0;
    @(negedge clk);
    curLine = YW'(line); textMode = tm;
    for (int c = 0; c < LB; c++) begin
      rdCol = CW'(c);
      @(negedge clk);
      if (pixByte !== memFn(pixSt + AW'(c)) ||
          (withAttr && attrByte !== memFn(attrSt + AW'(c)))) begin
        if (bad == 0) begin act = {attrByte, pixByte}; exp = {memFn(attrSt + AW'(c)), memFn(pixSt + AW'(c))}; end
        bad++;
      end
    end
    check(bad == 0, req, act, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busReq === 1'b0 && memRd === 1'b0 && pixByte === 0 && attrByte === 0,
          "R1 reset state", {busReq, memRd, pixByte, attrByte}, 0);

    // directed: bitmap burst with address wrap at the top of memory
    blankRun(10, 0, 14'h3F80, 100, "R2 bitmap burst wraps");
    readBack(11, 0, startOf(10, 0, 14'h3F80), 0, 0, "R9 R10 bitmap readback");

    // directed: text char row then attr row then a silent line
    blankRun(16, 1, 14'h0100, 100, "R3 text character burst");
    blankRun(17, 1, 14'h0100, 100, "R4 text attribute burst");
    blankRun(18, 1, 14'h0100, 100, "R5 no fetch on line 2 of row");
    blankRun(23, 1, 14'h0100, 100, "R5 no fetch on line 7 of row");
    readBack(24, 1, startOf(16, 1, 14'h0100), startOf(17, 1, 14'h0100), 1, "R4 R9 text readback");

    // directed: aborted burst drops request in the same cycle
    blankRun(40, 0, 14'h0000, 30, "R7 aborted burst");

    // random bursts on both banks; earlier bank must survive (R8)
    for (int it = 0; it < 16; it++) begin
      bit tm;
      logic [AW-1:0] base;
      tm = 1'($urandom);
      base = AW'($urandom);
      if (!tm) begin
        int l;
        l = int'($urandom % 190);
        blankRun(l, 0, base, 90, "R2 random bitmap burst");
        blankRun(l + 1, 0, base, 90, "R2 random bitmap burst next");
        readBack(l + 1, 0, startOf(l, 0, base), 0, 0, "R8 bitmap bank kept");
        readBack(l + 2, 0, startOf(l + 1, 0, base), 0, 0, "R8 bitmap other bank");
      end else begin
        int r;
        r = int'($urandom % 23);
        blankRun(8 * r, 1, base, 90, "R3 random char burst");
        blankRun(8 * r + 1, 1, base, 90, "R4 random attr burst");
        blankRun(8 * r + 2 + int'($urandom % 6), 1, base, 90, "R5 random silent line");
        blankRun(8 * r + 8, 1, base, 90, "R3 random char next row");
        readBack(8 * r + 8, 1, startOf(8 * r, 1, base), startOf(8 * r + 1, 1, base), 1,
                 "R8 text bank kept");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule